// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a small register-mapped master for the two-wire PHY management bus. Software writes one packed 32-bit command word. The word holds the start code, opcode, PHY address, register address, turnaround pattern and write data, in the order they appear on the wire. The controller then sends a preamble of ones followed by the whole word, MSB first, on the management clock and data pins. On a read frame, it releases the data pin for the PHY's reply. It shifts in the 16 returned bits and writes them into the low half of the same register.

When a frame finishes, the controller sets a sticky event flag, and software clears it by writing a one. A programmable divider derives the management clock from the system clock. A mode-enable bit gates whether commands are accepted. A busy bit lets software avoid writing while a frame is still on the wire.

Top module: `mdio_frame_ctrl`

The bank has four registers, each selected by a two-bit word address:

| Offset | Register | Contents |
|---|---|---|
| 0 | Control | Enable in bit 0 |
| 1 | Speed | Divisor in bits 6:1 |
| 2 | Command/data | The packed command word |
| 3 | Status | Event flag in bit 0, busy in bit 1 |

## Requirements
- R1: A frame sends 32 ones and then command bits 31 down to 0, one bit per MDC period. The command fields are: start code 01 in bits 31:30, opcode in bits 29:28 (10 read, 01 write), PHY address in 27:23, register address in 22:18, turnaround pattern 10 in 17:16 and write data in 15:0. On a write frame, the output enable is high for all 64 bits.
- R2: When a read frame completes, bits 15:0 of the command/data register (offset 2) hold the 16 bits sampled from the data input, first received bit in bit 15. Bits 31:16 keep the command.
- R3: Completing any frame sets bit 0 of the status register (offset 3). Writing one to that bit clears it, writing zero leaves it set, and a completion in the same cycle as a clear wins.
- R4: While a frame runs, MDC has a period of exactly 2*D system clocks, where D is the divisor field. MDC is low whenever the controller is idle.
- R5: The divisor is the 6-bit field at bits 6:1 of the speed register (offset 1). All other bits of that register read as zero and are unaffected by writes.
- R6: A command written while the enable bit (bit 0 of offset 0) is clear is ignored: no frame starts, no event is raised and the command/data register keeps its old value.
- R7: A command accepted while D is zero is held with busy set and MDC frozen. Its frame starts once D becomes nonzero.
- R8: Busy is bit 1 of the status register and is set from command acceptance to frame completion. A command written while busy is ignored and does not alter the command/data register or the frame in flight.
- R9: On a read frame, the output enable is low from bit 47 (the second turnaround bit) through bit 63 and high for bits 0 to 46.
- R10: The data output changes only at falling MDC edges or when a frame starts. The data input is sampled at rising MDC edges.
- R11: After reset, all registers read zero, and MDC, the data output and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data pin output value |
| mdioOe | output | 1 | Data pin output enable |
| mdioIn | input | 1 | Data pin input value |

## Verification
The assertions check, on every cycle, four properties:
- MDC stays low when idle and is frozen under a zero divisor.
- The data output never moves on a rising MDC edge.
- The event flag holds until a write-one clear and is set after every completion.
- A disabled controller never becomes busy, and the command word holds while busy.

Other behaviours are only visible in the bench's scenarios, using a behavioural PHY with a register file:
- the exact 64-bit wire order for writes
- the turnaround release window and returned data for reads
- the exact MDC period for several divisors
- the deferred start after a zero divisor is replaced

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef struct packed {
    logic startFrame;
    logic isRead;
  } mdioStrobe_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_SPEED = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;
  localparam logic [1:0] ADDR_EVENT = 2'd3;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mdio_control.sv
module mdio_control
  import mdio_pkg::*;
#(
  parameter int CMD_W  = 32,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [CMD_W-1:0]  regWrData,
  output logic [CMD_W-1:0]  regRdData,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] rdData,
  output mdioStrobe_t       strobe,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [DIV_W-1:0]  divField,
  output logic              busy,
  output logic              evtFlag,
  output logic              enBit
);

  localparam int OP_LSB = CMD_W - 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_DIV,
    ST_RUN
  } ctrlState_t;

  ctrlState_t state;
  logic [CMD_W-1:0] dataReg;

  logic wrCtrl;
  logic wrSpeed;
  logic wrData;
  logic wrEvent;
  logic cmdIsRead;

  assign wrCtrl    = regWrEn && (regAddr == ADDR_CTRL);
  assign wrSpeed   = regWrEn && (regAddr == ADDR_SPEED);
  assign wrData    = regWrEn && (regAddr == ADDR_DATA);
  assign wrEvent   = regWrEn && (regAddr == ADDR_EVENT);
  assign cmdIsRead = (dataReg[OP_LSB +: 2] == OP_READ);

  always_comb begin
    strobe.startFrame = (state == ST_WAIT_DIV) && (divField != '0);
    strobe.isRead     = cmdIsRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dataReg  <= '0;
      divField <= '0;
      evtFlag  <= 1'b0;
      enBit    <= 1'b0;
    end else begin
      if (wrCtrl) enBit <= regWrData[0];
      if (wrSpeed) divField <= regWrData[DIV_W:1];

      if (frameDone) evtFlag <= 1'b1;
      else if (wrEvent && regWrData[0]) evtFlag <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (wrData && enBit) begin
            dataReg <= regWrData;
            state   <= ST_WAIT_DIV;
          end
        end
        ST_WAIT_DIV: begin
          if (strobe.startFrame) state <= ST_RUN;
        end
        ST_RUN: begin
          if (frameDone) begin
            state <= ST_IDLE;
            if (cmdIsRead) dataReg[DATA_W-1:0] <= rdData;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign cmdWord = dataReg;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:  regRdData[0] = enBit;
      ADDR_SPEED: regRdData[DIV_W:1] = divField;
      ADDR_DATA:  regRdData = dataReg;
      default: begin
        regRdData[0] = evtFlag;
        regRdData[1] = busy;
      end
    endcase
  end

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16,
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrobe_t       strobe,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [DIV_W-1:0]  divField,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              frameDone,
  output logic [DATA_W-1:0] rdData
);

  localparam int TOTAL = PRE_LEN + CMD_W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] SHIFT_IDX = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] CMD_IDX = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] REL_IDX = IDX_W'(TOTAL - DATA_W - 1);
  localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(TOTAL - DATA_W);

  logic              active;
  logic              isRd;
  logic              mdcR;
  logic [IDX_W-1:0]  bitIdx;
  logic [DIV_W-1:0]  divCnt;
  logic [CMD_W-1:0]  shCmd;
  logic [DATA_W-1:0] capReg;
  logic              tick;

  assign tick = active && (divField != '0) &&
                (({1'b0, divCnt} + (DIV_W+1)'(1)) >= {1'b0, divField});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      isRd      <= 1'b0;
      mdcR      <= 1'b0;
      bitIdx    <= '0;
      divCnt    <= '0;
      shCmd     <= '0;
      capReg    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobe.startFrame) begin
        active <= 1'b1;
        isRd   <= strobe.isRead;
        mdcR   <= 1'b0;
        bitIdx <= '0;
        divCnt <= '0;
        shCmd  <= cmdWord;
        capReg <= '0;
      end else if (active) begin
        if (tick) begin
          divCnt <= '0;
          if (!mdcR) begin
            mdcR <= 1'b1;
            if (isRd && (bitIdx >= CAP_IDX))
              capReg <= {capReg[DATA_W-2:0], mdioIn};
          end else begin
            mdcR <= 1'b0;
            if (bitIdx == LAST_IDX) begin
              active    <= 1'b0;
              frameDone <= 1'b1;
            end else begin
              bitIdx <= bitIdx + IDX_W'(1);
              if (bitIdx >= SHIFT_IDX)
                shCmd <= {shCmd[CMD_W-2:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end
    end
  end

  assign mdc     = mdcR;
  assign mdioOut = active && ((bitIdx < CMD_IDX) || shCmd[CMD_W-1]);
  assign mdioOe  = active && !(isRd && (bitIdx >= REL_IDX));
  assign rdData  = capReg;

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  localparam int CMD_W  = 32;
  localparam int DATA_W = CMD_W / 2;

  mdioStrobe_t       ctrlStrobe;
  logic [CMD_W-1:0]  cmdWord;
  logic [DIV_W-1:0]  divField;
  logic              busyFlag;
  logic              evtFlag;
  logic              enBit;
  logic              frameDone;
  logic [DATA_W-1:0] rdData;

  mdio_control #(.CMD_W(CMD_W), .DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData),
    .frameDone(frameDone), .rdData(rdData),
    .strobe(ctrlStrobe), .cmdWord(cmdWord), .divField(divField),
    .busy(busyFlag), .evtFlag(evtFlag), .enBit(enBit)
  );

  mdio_datapath #(.CMD_W(CMD_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
                  .PRE_LEN(PRE_LEN)) uPath (
    .clk(clk), .rstN(rstN),
    .strobe(ctrlStrobe), .cmdWord(cmdWord), .divField(divField),
    .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .frameDone(frameDone), .rdData(rdData)
  );

endmodule

// File: rtl/mdio_frame_checker.sv
module mdio_frame_checker #(
  parameter int DIV_W = 6,
  parameter int CMD_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             mdc,
  input logic             mdioOut,
  input logic             busy,
  input logic             evtFlag,
  input logic             enBit,
  input logic             frameDone,
  input logic             cmdWrite,
  input logic             evtWrOne,
  input logic [DIV_W-1:0] divField,
  input logic [CMD_W-1:0] cmdWord
);

  a_r4_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  a_r10_out_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> $stable(mdioOut));

  a_r3_evt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !evtWrOne) |=> evtFlag);

  a_r3_evt_set: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> evtFlag);

  a_r7_zero_div_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (divField == '0) |=> $stable(mdc));

  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !enBit) |=> !busy);

  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !frameDone && cmdWrite) |=> $stable(cmdWord));

endmodule

bind mdio_frame_ctrl mdio_frame_checker #(.DIV_W(DIV_W), .CMD_W(32)) uChk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOut(mdioOut),
  .busy(busyFlag), .evtFlag(evtFlag), .enBit(enBit), .frameDone(frameDone),
  .cmdWrite(regWrEn && (regAddr == 2'd2)),
  .evtWrOne(regWrEn && (regAddr == 2'd3) && regWrData[0]),
  .divField(divField), .cmdWord(cmdWord)
);

// File: tb/tb_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_frame_ctrl;

  localparam logic [4:0] PHY_ADDR = 5'd3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int vecCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  logic [63:0] capVec;
  logic [63:0] oeVec;
  int capIdx = 0;
  int riseCnt = 0;
  time prevRise = 0;
  bit hasPrev = 1'b0;
  time minPer, maxPer;
  logic [15:0] phyRegs [32];
  logic [15:0] rdVal;
  bit phyDrive = 1'b0;

  always #4 clk = ~clk;

  mdio_frame_ctrl dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // Capture the wire at each rising MDC edge (R10: sampling edge)
  always @(posedge mdc) begin
    riseCnt = riseCnt + 1;
    if (capIdx < 64) begin
      capVec[63-capIdx] = mdioOut;
      oeVec[63-capIdx]  = mdioOe;
      capIdx = capIdx + 1;
    end
    if (hasPrev) begin
      if ($time - prevRise < minPer) minPer = $time - prevRise;
      if ($time - prevRise > maxPer) maxPer = $time - prevRise;
    end
    prevRise = $time;
    hasPrev = 1'b1;
  end

  // Behavioural PHY: drives turnaround zero and read data after falling edges
  always @(negedge mdc) begin
    if (capIdx == 47) begin
      if (capVec[29:28] == 2'b10 && capVec[27:23] == PHY_ADDR) begin
        phyDrive = 1'b1;
        rdVal = phyRegs[capVec[22:18]];
        mdioIn <= 1'b0;
      end
    end else if (phyDrive && capIdx >= 48 && capIdx <= 63) begin
      mdioIn <= rdVal[63-capIdx];
    end else begin
      phyDrive = 1'b0;
      mdioIn <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    vecCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  function automatic logic [31:0] mkCmd(input logic [1:0] op, input logic [4:0] phy,
                                        input logic [4:0] ra, input logic [15:0] dat);
    return {2'b01, op, phy, ra, 2'b10, dat};
  endfunction

  task automatic armCapture();
    capIdx = 0; riseCnt = 0; hasPrev = 1'b0;
    minPer = 64'd1_000_000; maxPer = 0;
    capVec = '0; oeVec = '0;
  endtask

  task automatic waitEvt(output bit got);
    logic [31:0] v;
    got = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd3, v);
      if (v[0]) begin got = 1'b1; break; end
    end
  endtask

  task automatic runFrame(input logic [31:0] cmd, output bit got);
    wr(2'd3, 32'd1);
    armCapture();
    wr(2'd2, cmd);
    waitEvt(got);
    if (got && cmd[29:28] == 2'b01 && cmd[27:23] == PHY_ADDR)
      phyRegs[cmd[22:18]] = cmd[15:0];
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] cmd;
    logic [31:0] prevData;
    bit got;
    for (int r = 0; r < 32; r++) phyRegs[r] = 16'h1357 ^ (16'h0F21 * 16'(r));
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R11: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R11 reset register", 64'(v), 64'd0);
    end
    check(!mdc && !mdioOut && !mdioOe, "R11 reset pins", {61'd0, mdc, mdioOut, mdioOe}, 64'd0);

    // R5: speed field only bits 6:1
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v);
    check(v == 32'h0000_007E, "R5 speed readback", 64'(v), 64'h7E);

    // R6: disabled controller ignores command
    wr(2'd1, 32'd2 << 1);
    armCapture();
    wr(2'd2, mkCmd(2'b01, PHY_ADDR, 5'd1, 16'hBEEF));
    repeat (300) @(posedge clk);
    rd(2'd3, v);
    check(v[1:0] == 2'b00, "R6 no busy/event when disabled", 64'(v[1:0]), 64'd0);
    check(riseCnt == 0, "R6 no MDC when disabled", 64'(riseCnt), 64'd0);
    rd(2'd2, v);
    check(v == 0, "R6 data register untouched", 64'(v), 64'd0);

    wr(2'd0, 32'd1);

    // R1/R4/R3: write sweep over divisors and registers
    for (int k = 0; k < 4; k++) begin
      int dv;
      logic [4:0] ra;
      dv = (k == 3) ? 5 : k + 1;
      ra = (k == 0) ? 5'd0 : (k == 1) ? 5'd7 : (k == 2) ? 5'd21 : 5'd31;
      wr(2'd1, 32'(dv) << 1);
      cmd = mkCmd(2'b01, PHY_ADDR, ra, 16'hA5C3 ^ (16'h1111 * 16'(k)));
      runFrame(cmd, got);
      check(got, "R3 event after write frame", 64'(got), 64'd1);
      check(capIdx == 64 && capVec == {32'hFFFF_FFFF, cmd}, "R1 write frame bits",
            capVec, {32'hFFFF_FFFF, cmd});
      check(oeVec == 64'hFFFF_FFFF_FFFF_FFFF, "R1 write enable all bits", oeVec,
            64'hFFFF_FFFF_FFFF_FFFF);
      check(minPer == 16 * dv && maxPer == 16 * dv, "R4 MDC period",
            64'(maxPer), 64'(16 * dv));
      check(!mdc, "R4 MDC low after frame", 64'(mdc), 64'd0);
    end

    // R3: write zero keeps, write one clears
    wr(2'd3, 32'd0);
    rd(2'd3, v);
    check(v[0] == 1'b1, "R3 write zero keeps event", 64'(v[0]), 64'd1);
    wr(2'd3, 32'd1);
    rd(2'd3, v);
    check(v[0] == 1'b0, "R3 write one clears event", 64'(v[0]), 64'd0);

    // R2/R9: read frames from written and preset registers, plus absent PHY
    wr(2'd1, 32'd3 << 1);
    for (int k = 0; k < 5; k++) begin
      logic [4:0] ra;
      logic [4:0] pa;
      logic [15:0] expv;
      ra = (k == 0) ? 5'd7 : (k == 1) ? 5'd21 : (k == 2) ? 5'd9 : (k == 3) ? 5'd30 : 5'd2;
      pa = (k == 4) ? 5'd17 : PHY_ADDR;
      expv = (pa == PHY_ADDR) ? phyRegs[ra] : 16'hFFFF;
      cmd = mkCmd(2'b10, pa, ra, 16'h0000);
      runFrame(cmd, got);
      rd(2'd2, v);
      check(got && v == {cmd[31:16], expv}, "R2 read data register",
            64'(v), 64'({cmd[31:16], expv}));
      check(oeVec == 64'hFFFF_FFFF_FFFE_0000, "R9 read release window", oeVec,
            64'hFFFF_FFFF_FFFE_0000);
      check(capVec[63:17] == {32'hFFFF_FFFF, cmd[31:17]}, "R1 read header bits",
            64'(capVec[63:17]), 64'({32'hFFFF_FFFF, cmd[31:17]}));
    end

    // R7: zero divisor holds the command
    wr(2'd1, 32'd0);
    wr(2'd3, 32'd1);
    armCapture();
    cmd = mkCmd(2'b01, PHY_ADDR, 5'd12, 16'h0F0F);
    wr(2'd2, cmd);
    repeat (200) @(posedge clk);
    rd(2'd3, v);
    check(v[1:0] == 2'b10, "R7 waiting busy without event", 64'(v[1:0]), 64'd2);
    check(riseCnt == 0 && !mdc, "R7 MDC frozen", 64'(riseCnt), 64'd0);
    wr(2'd1, 32'd2 << 1);
    waitEvt(got);
    check(got && capVec == {32'hFFFF_FFFF, cmd}, "R7 deferred frame", capVec,
          {32'hFFFF_FFFF, cmd});

    // R8: command during busy ignored
    wr(2'd3, 32'd1);
    armCapture();
    cmd = mkCmd(2'b01, PHY_ADDR, 5'd4, 16'h1234);
    prevData = mkCmd(2'b10, PHY_ADDR, 5'd5, 16'h0000);
    wr(2'd2, cmd);
    repeat (40) @(posedge clk);
    rd(2'd3, v);
    check(v[1] == 1'b1, "R8 busy during frame", 64'(v[1]), 64'd1);
    wr(2'd2, prevData);
    rd(2'd2, v);
    check(v == cmd, "R8 data register kept", 64'(v), 64'(cmd));
    waitEvt(got);
    repeat (600) @(posedge clk);
    check(riseCnt == 64 && capVec == {32'hFFFF_FFFF, cmd}, "R8 single frame",
          64'(riseCnt), 64'd64);
    rd(2'd3, v);
    check(v[1] == 1'b0, "R8 busy clears after frame", 64'(v[1]), 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vecCnt++;
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

endmodule